// File: doc/BRIEF.md
# Complex Radix-2 Butterfly with Growth Flag

This block computes one decimation-in-time radix-2 butterfly per clock on complex 16-bit fractional data (one sign bit, fifteen fraction bits). From operands A and B and a twiddle factor W it produces A' = A + W·B and B' = A − W·B. The real and imaginary parts of the product W·B are each formed from two full-precision 32-bit products, rounded to nearest and saturated back to 16 bits. The two outputs are then formed from these parts with saturating addition.

Two twiddle values skip the multipliers: unity (the largest positive code on the real part, zero imaginary) and minus j. With these, the results of the first two transform stages are exact sums and differences. A growth flag travels with each output beat. It tells a block floating-point controller that at least one output component has used up the headroom kept for the next stage, so that stage's data needs shifting down. A per-beat mode input selects one bit of headroom (early stages) or two bits (later stages, where a butterfly can grow by about 2.414).

Top module: `bfly_r2_growth`

## Requirements
- R1: For each valid beat, the A output is sat(A + T) and the B output is sat(A − T), real and imaginary parts taken separately. T is the twiddled B operand.
- R2: For a general twiddle, T.re = rnd(Br·Wr − Bi·Wi) and T.im = rnd(Br·Wi + Bi·Wr), where rnd(p) adds 16384 to the exact product sum, shifts it arithmetically right by 15 and saturates.
- R3: When w_re = 16'h7FFF and w_im = 0, T equals B exactly.
- R4: When w_re = 0 and w_im = 16'h8000, T.re = Bi and T.im = sat(−Br).
- R5: Every saturation clamps to the range −32768 … 32767 and never wraps.
- R6: out_vld is in_vld delayed by exactly three clock edges, and its data belongs to that same input beat.
- R7: When hr_two = 0 on the beat, grow is 1 exactly when some output component x satisfies x ≥ 16384 or x ≤ −16384.
- R8: When hr_two = 1 on the beat, grow uses the threshold 8192 in place of 16384. grow is 0 whenever out_vld is 0.
- R9: While rst_n is low, out_vld, grow and all four output components are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input beat valid |
| hr_two | input | 1 | 1 selects two-bit headroom threshold |
| a_re | input | 16 | Operand A real |
| a_im | input | 16 | Operand A imaginary |
| b_re | input | 16 | Operand B real |
| b_im | input | 16 | Operand B imaginary |
| w_re | input | 16 | Twiddle real |
| w_im | input | 16 | Twiddle imaginary |
| out_vld | output | 1 | Output beat valid |
| pa_re | output | 16 | A' real |
| pa_im | output | 16 | A' imaginary |
| pb_re | output | 16 | B' real |
| pb_im | output | 16 | B' imaginary |
| grow | output | 1 | Headroom exceeded on this beat |

## Verification
The assertions assume that the operands, twiddle and mode of a beat are sampled only on the edge where in_vld is high, and that reset is held long enough to clear all three pipeline stages. Their three-cycle look-back is gated by a counter of edges since reset. The stimulus holds in_vld low throughout reset and drives the inputs just after each edge. It sends bursts with gaps, trivial and general twiddles, operands at the extreme codes, and outputs placed on either side of both growth thresholds.

// File: rtl/bfly_r2_growth.sv
module bfly_r2_growth #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 hr_two,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic                 out_vld,
  output logic signed [DW-1:0] pa_re,
  output logic signed [DW-1:0] pa_im,
  output logic signed [DW-1:0] pb_re,
  output logic signed [DW-1:0] pb_im,
  output logic                 grow
);
  localparam int PW = 2*DW + 2;
  localparam int FB = DW - 1;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] T1 = {2'b01, {(DW-2){1'b0}}};
  localparam logic signed [DW-1:0] T2 = {3'b001, {(DW-3){1'b0}}};

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] x);
    if (x > PW'(MAXV))      sat = MAXV;
    else if (x < PW'(MINV)) sat = MINV;
    else                    sat = x[DW-1:0];
  endfunction

  function automatic logic over(input logic signed [DW-1:0] x,
                                input logic signed [DW-1:0] t);
    over = (x >= t) || (x <= -t);
  endfunction

  // stage 1: products and twiddle class
  logic                 v1, h1, u1, j1;
  logic signed [DW-1:0] ar1, ai1, br1, bi1;
  logic signed [2*DW-1:0] prr, pii, pri, pir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; h1 <= 1'b0; u1 <= 1'b0; j1 <= 1'b0;
      ar1 <= '0; ai1 <= '0; br1 <= '0; bi1 <= '0;
      prr <= '0; pii <= '0; pri <= '0; pir <= '0;
    end else begin
      v1  <= in_vld;
      h1  <= hr_two;
      u1  <= (w_re == MAXV) && (w_im == '0);
      j1  <= (w_re == '0) && (w_im == MINV);
      ar1 <= a_re; ai1 <= a_im; br1 <= b_re; bi1 <= b_im;
      prr <= b_re * w_re;
      pii <= b_im * w_im;
      pri <= b_re * w_im;
      pir <= b_im * w_re;
    end
  end

  // stage 2: round, saturate, select twiddled operand
  logic signed [PW-1:0] sre, sim;
  logic signed [DW-1:0] tre_c, tim_c;
  assign sre = (PW'(prr) - PW'(pii) + PW'(1 <<< (FB-1))) >>> FB;
  assign sim = (PW'(pri) + PW'(pir) + PW'(1 <<< (FB-1))) >>> FB;

  always_comb begin
    if (u1) begin
      tre_c = br1; tim_c = bi1;
    end else if (j1) begin
      tre_c = bi1; tim_c = sat(-PW'(br1));
    end else begin
      tre_c = sat(sre); tim_c = sat(sim);
    end
  end

  logic                 v2, h2;
  logic signed [DW-1:0] ar2, ai2, tr2, ti2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; h2 <= 1'b0;
      ar2 <= '0; ai2 <= '0; tr2 <= '0; ti2 <= '0;
    end else begin
      v2 <= v1; h2 <= h1;
      ar2 <= ar1; ai2 <= ai1; tr2 <= tre_c; ti2 <= tim_c;
    end
  end

  // stage 3: saturating sum/difference and growth check
  logic signed [DW-1:0] nar, nai, nbr, nbi, thr;
  assign nar = sat(PW'(ar2) + PW'(tr2));
  assign nai = sat(PW'(ai2) + PW'(ti2));
  assign nbr = sat(PW'(ar2) - PW'(tr2));
  assign nbi = sat(PW'(ai2) - PW'(ti2));
  assign thr = h2 ? T2 : T1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0; grow <= 1'b0;
      pa_re <= '0; pa_im <= '0; pb_re <= '0; pb_im <= '0;
    end else begin
      out_vld <= v2;
      grow    <= v2 && (over(nar, thr) || over(nai, thr) ||
                        over(nbr, thr) || over(nbi, thr));
      pa_re <= nar; pa_im <= nai; pb_re <= nbr; pb_im <= nbi;
    end
  end
endmodule

// File: rtl/bfly_r2_growth_chk.sv
module bfly_r2_growth_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               in_vld,
  input logic signed [15:0] a_re,
  input logic signed [15:0] b_re,
  input logic signed [15:0] b_im,
  input logic signed [15:0] w_re,
  input logic signed [15:0] w_im,
  input logic               out_vld,
  input logic signed [15:0] pa_re,
  input logic signed [15:0] pa_im,
  input logic signed [15:0] pb_re,
  input logic               grow
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  function automatic logic signed [15:0] s16(input int x);
    s16 = (x > 32767) ? 16'sh7FFF : (x < -32768) ? 16'sh8000 : 16'(x);
  endfunction

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));

  a_r8_flag_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    grow |-> out_vld);

  a_r7_big_output_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (pa_re >= 16'sd16384 || pa_im <= -16'sd16384)) |-> grow);

  a_r3_unity_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_vld && $past(w_re, 3) == 16'sh7FFF && $past(w_im, 3) == 16'sh0)
    |-> (pa_re == s16(int'($past(a_re, 3)) + int'($past(b_re, 3)))));

  a_r4_minus_j: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_vld && $past(w_re, 3) == 16'sh0 && $past(w_im, 3) == 16'sh8000)
    |-> (pb_re == s16(int'($past(a_re, 3)) - int'($past(b_im, 3)))));
endmodule

bind bfly_r2_growth bfly_r2_growth_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a_re(a_re), .b_re(b_re),
  .b_im(b_im), .w_re(w_re), .w_im(w_im), .out_vld(out_vld), .pa_re(pa_re),
  .pa_im(pa_im), .pb_re(pb_re), .grow(grow)
);

// File: tb/sim_bfly_r2_growth.sv
module sim_bfly_r2_growth;
  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0, hr_two = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
  logic out_vld, grow;
  logic signed [15:0] pa_re, pa_im, pb_re, pb_im;
  int total = 0, bad = 0;
  string tag = "R9";

  always #5 clk = ~clk;

  bfly_r2_growth u0 (.*);

  function automatic int sat(input longint x);
    sat = (x > 32767) ? 32767 : (x < -32768) ? -32768 : int'(x);
  endfunction

  function automatic int rnd(input longint p);
    rnd = sat((p + 64'sd16384) >>> 15);
  endfunction

  function automatic bit big(input int x, input int t);
    big = (x >= t) || (x <= -t);
  endfunction

  // expected beats, indexed by edges since capture
  int ev[3], ear[3], eai[3], ebr[3], ebi[3], eg[3];

  always @(posedge clk) begin
    int tr, ti, xr, xi, yr, yi, th;
    for (int k = 2; k > 0; k--) begin
      ev[k] = ev[k-1]; ear[k] = ear[k-1]; eai[k] = eai[k-1];
      ebr[k] = ebr[k-1]; ebi[k] = ebi[k-1]; eg[k] = eg[k-1];
    end
    if (w_re == 16'sh7FFF && w_im == 0) begin tr = b_re; ti = b_im; end
    else if (w_re == 0 && w_im == 16'sh8000) begin tr = b_im; ti = sat(-longint'(b_re)); end
    else begin
      tr = rnd(longint'(b_re) * w_re - longint'(b_im) * w_im);
      ti = rnd(longint'(b_re) * w_im + longint'(b_im) * w_re);
    end
    xr = sat(longint'(a_re) + tr); xi = sat(longint'(a_im) + ti);
    yr = sat(longint'(a_re) - tr); yi = sat(longint'(a_im) - ti);
    th = hr_two ? 8192 : 16384;
    ev[0] = (rst_n && in_vld) ? 1 : 0;
    ear[0] = xr; eai[0] = xi; ebr[0] = yr; ebi[0] = yi;
    eg[0] = (ev[0] == 1) && (big(xr, th) || big(xi, th) || big(yr, th) || big(yi, th));
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R6", int'(out_vld), ev[2]);
    if (ev[2] == 1) begin
      chk({tag, "/R1 pa_re"}, pa_re, ear[2]);
      chk({tag, "/R1 pa_im"}, pa_im, eai[2]);
      chk({tag, "/R1 pb_re"}, pb_re, ebr[2]);
      chk({tag, "/R1 pb_im"}, pb_im, ebi[2]);
    end
    chk({tag, "/R7/R8 grow"}, int'(grow), eg[2]);
  end

  task automatic beat(input int ar, ai, br, bi, wr, wi, input bit m);
    @(posedge clk); #1;
    in_vld = 1; hr_two = m;
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    w_re = 16'(wr); w_im = 16'(wi);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; in_vld = 0; end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 vld", int'(out_vld), 0); chk("R9 grow", int'(grow), 0);
    chk("R9 pa_re", pa_re, 0); chk("R9 pb_im", pb_im, 0);
    rst_n = 1;
    tag = "R3";
    beat(1000, -2000, 300, 400, 32767, 0, 0);
    beat(-5000, 7000, -32768, 32767, 32767, 0, 0);
    idle(2);
    tag = "R4";
    beat(100, 200, 3000, -4000, 0, -32768, 0);
    beat(0, 0, -32768, 5, 0, -32768, 1);
    idle(3);
    tag = "R2";
    beat(1000, 1000, 23170, 23170, 23170, -23170, 1);
    beat(-1, 1, 1, 1, 1, 1, 0);
    beat(0, 0, -32768, -32768, -32768, -32768, 0);
    beat(0, 0, 3, 0, 16384, 0, 0);
    for (int i = 0; i < 200; i++)
      beat($urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
           $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
           1'($urandom_range(0, 1)));
    idle(1);
    tag = "R5";
    beat(32767, -32768, 32767, -32768, 32767, 0, 0);
    beat(-32768, 32767, 32767, -32768, 32767, 0, 0);
    idle(2);
    tag = "R7";
    beat(16383, 0, 0, 0, 32767, 0, 0);
    beat(16384, 0, 0, 0, 32767, 0, 0);
    beat(0, -16384, 0, 0, 32767, 0, 0);
    beat(8192, 0, 0, 0, 32767, 0, 0);
    tag = "R8";
    beat(8191, 0, 0, 0, 32767, 0, 1);
    beat(8192, 0, 0, 0, 32767, 0, 1);
    beat(0, 0, 0, -8192, 32767, 0, 1);
    idle(1);
    tag = "R6";
    beat(10, 20, 30, 40, 32767, 0, 0);
    idle(3);
    beat(50, 60, 70, 80, 0, -32768, 0);
    idle(6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule